// File: doc/BRIEF.md
# Countdown Timer Bank with Timestamp Counter

This block holds three countdown timers and one free-running up-counting timestamp counter. All of them sit behind a single 32-bit register port. The first two countdown channels are 16 bits wide and the third is 32 bits wide. Each channel has a load register, a read-only value register, a control register and an interrupt-clear register. A channel that underflows raises its own interrupt line, and that line stays high until software clears it.

Each channel counts on one of two clock-enable strobes that come in from outside the block: a slow tick and a fast tick. The channel's control register picks which one it uses. The timestamp counter is 40 bits wide and always counts on the fast tick. It has no interrupt. Software reads it as a low word and a high word, and turns it on or off through the high word.

A typical start-up sequence for a periodic channel has three writes. First write control with the enable bit clear, then write the load value, then write control again with the enable bit set (for example 0x48, the load, then 0xC8). A load of N-1 then gives one interrupt every N ticks.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every control register reads zero, every value and load register reads zero, all interrupt lines are low and the timestamp counter is disabled with a count of zero.
- R2: A channel decrements by one on each active edge where its control bit 7 (enable) is set and its selected tick is high. Control bit 3 set selects the slow tick and bit 3 clear selects the fast tick. A disabled channel holds its value.
- R3: A control write that changes the enable bit from 0 to 1 copies the load register into the value register.
- R4: With control bit 6 set (periodic), a tick at value 0 reloads the load register, so a load of N-1 gives an underflow every N ticks.
- R5: With control bit 6 clear (free-running), a tick at value 0 reloads all ones of the channel width: 0xFFFF on the 16-bit channels and 0xFFFFFFFF on the 32-bit channel.
- R6: An underflow sets the channel's interrupt line (irq bit k for channel k). It stays set until any write to that channel's clear register. If an underflow and a clear write fall on the same edge, the interrupt stays set.
- R7: A load write to an enabled channel also replaces its value at once. A load write to a disabled channel changes only the load register.
- R8: Value reads of the 16-bit channels return zero in bits 31:16. Control reads return only bits 7, 6 and 3, with every other bit zero.
- R9: The timestamp counter is enabled by bit 8 of its high register. While enabled it increments on each fast tick. While disabled it is held at zero. The low register reads count bits 31:0. The high register reads count bits 39:32 in bits 7:0 and the enable in bit 8.
- R10: Writes to the value registers and to the timestamp low register are ignored.
- R11: Register map by byte address, word aligned. Channel k (0 to 2) has its base at 0x10·k, with load at +0x0, value at +0x4, control at +0x8 and clear at +0xC. The timestamp low register is at 0x30 and the high register is at 0x34. Any other address, including a misaligned one, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Clock enable for the slow count rate |
| fast_tick | input | 1 | Clock enable for the fast count rate and the timestamp |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Underflow interrupt, one line per countdown channel |

## Verification
The bench goes after the edges of the count. It checks the exact tick on which a periodic channel wraps. A design with an off-by-one there would raise the interrupt one tick early or late and reload the wrong value. It also checks an underflow that lands on the same edge as a clear write. A design that lets the clear win would drop that event. The bench checks that a load write to a disabled channel leaves the value alone, that the unselected tick does nothing, and that free-running reload gives all ones of the correct width. A design that got any of these wrong would show a wrong value read back or a wrong interrupt pattern. For the timestamp counter, the bench checks that the low word counts only fast ticks, that writes to the low word are ignored, and that clearing the enable returns the count to zero.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // Word offsets inside a countdown channel window
  localparam logic [1:0] OFF_LOAD  = 2'd0;
  localparam logic [1:0] OFF_VALUE = 2'd1;
  localparam logic [1:0] OFF_CTRL  = 2'd2;
  localparam logic [1:0] OFF_CLEAR = 2'd3;

  // Channel window index used by the timestamp counter
  localparam logic [1:0] STAMP_WIN = 2'd3;
  localparam logic [1:0] OFF_ST_LO = 2'd0;
  localparam logic [1:0] OFF_ST_HI = 2'd1;

  // Control field positions
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_SLOW_BIT = 3;
  localparam int STAMP_EN_BIT  = 8;

  typedef struct packed {
    logic en;
    logic periodic;
    logic slow_sel;
  } ctrl_t;

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CTRL_EN_BIT]   = c.en;
    w[CTRL_PER_BIT]  = c.periodic;
    w[CTRL_SLOW_BIT] = c.slow_sel;
    return w;
  endfunction
endpackage

// File: rtl/tmr_decode.sv
`timescale 1ns/1ps
module tmr_decode #(
  parameter int NCH    = 3,
  parameter int ADDR_W = 6
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NCH-1:0]    wr_load,
  output logic [NCH-1:0]    wr_ctrl,
  output logic [NCH-1:0]    wr_clear,
  output logic              st_wr_hi,
  output logic              aligned,
  output logic [1:0]        win,
  output logic [1:0]        off
);
  import tmr_pkg::*;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign win     = bus_addr[5:4];
  assign off     = bus_addr[3:2];

  always_comb begin
    wr_load  = '0;
    wr_ctrl  = '0;
    wr_clear = '0;
    for (int k = 0; k < NCH; k++) begin
      if (bus_wr && aligned && (win == 2'(k))) begin
        wr_load[k]  = (off == OFF_LOAD);
        wr_ctrl[k]  = (off == OFF_CTRL);
        wr_clear[k] = (off == OFF_CLEAR);
      end
    end
    st_wr_hi = bus_wr && aligned && (win == STAMP_WIN) && (off == OFF_ST_HI);
  end
endmodule

// File: rtl/tmr_countdown.sv
`timescale 1ns/1ps
module tmr_countdown #(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          fast_tick,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic          wr_clear,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  value,
  output logic [W-1:0]  load,
  output tmr_pkg::ctrl_t ctrl,
  output logic          irq
);
  import tmr_pkg::*;

  logic         tick;
  logic         step;
  logic         underflow;
  logic         en_rise;
  logic [W-1:0] reload;
  logic [W-1:0] value_nxt;

  assign tick      = ctrl.slow_sel ? slow_tick : fast_tick;
  assign step      = ctrl.en && tick;
  assign underflow = step && (value == '0);
  assign en_rise   = wr_ctrl && wdata[CTRL_EN_BIT] && !ctrl.en;
  assign reload    = ctrl.periodic ? load : {W{1'b1}};

  always_comb begin
    value_nxt = value;
    if (wr_load && ctrl.en)
      value_nxt = wdata;
    else if (en_rise)
      value_nxt = load;
    else if (underflow)
      value_nxt = reload;
    else if (step)
      value_nxt = value - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      load  <= '0;
      ctrl  <= '0;
      irq   <= 1'b0;
    end else begin
      value <= value_nxt;
      if (wr_load)
        load <= wdata;
      if (wr_ctrl) begin
        ctrl.en       <= wdata[CTRL_EN_BIT];
        ctrl.periodic <= wdata[CTRL_PER_BIT];
        ctrl.slow_sel <= wdata[CTRL_SLOW_BIT];
      end
      if (underflow)
        irq <= 1'b1;
      else if (wr_clear)
        irq <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_stamp.sv
`timescale 1ns/1ps
module tmr_stamp #(
  parameter int STAMP_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fast_tick,
  input  logic               wr_hi,
  input  logic               wr_en_bit,
  output logic               en,
  output logic [STAMP_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      count <= '0;
    end else begin
      if (wr_hi)
        en <= wr_en_bit;
      if (!en)
        count <= '0;
      else if (fast_tick)
        count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank #(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int STAMP_W  = 40,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [2:0]        irq
);
  import tmr_pkg::*;

  localparam int NCH        = 3;
  localparam int STAMP_HI_W = STAMP_W - 32;

  logic [NCH-1:0] wr_load, wr_ctrl, wr_clear;
  logic           st_wr_hi;
  logic           aligned;
  logic [1:0]     win, off;

  logic [31:0]    ch_val  [NCH];
  logic [31:0]    ch_load [NCH];
  logic [31:0]    ch_ctrl [NCH];
  logic [NCH-1:0] ch_en;

  logic               st_en;
  logic [STAMP_W-1:0] st_cnt;

  tmr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_load  (wr_load),
    .wr_ctrl  (wr_ctrl),
    .wr_clear (wr_clear),
    .st_wr_hi (st_wr_hi),
    .aligned  (aligned),
    .win      (win),
    .off      (off)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam int W = (k == NCH - 1) ? WIDE_W : NARROW_W;
    logic [W-1:0] value;
    logic [W-1:0] load;
    ctrl_t        ctrl;

    tmr_countdown #(.W(W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .wr_load   (wr_load[k]),
      .wr_ctrl   (wr_ctrl[k]),
      .wr_clear  (wr_clear[k]),
      .wdata     (bus_wdata[W-1:0]),
      .value     (value),
      .load      (load),
      .ctrl      (ctrl),
      .irq       (irq[k])
    );

    assign ch_val[k]  = 32'(value);
    assign ch_load[k] = 32'(load);
    assign ch_ctrl[k] = ctrl_to_word(ctrl);
    assign ch_en[k]   = ctrl.en;
  end

  tmr_stamp #(.STAMP_W(STAMP_W)) u_stamp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .wr_hi     (st_wr_hi),
    .wr_en_bit (bus_wdata[STAMP_EN_BIT]),
    .en        (st_en),
    .count     (st_cnt)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (win == STAMP_WIN) begin
        if (off == OFF_ST_LO)
          bus_rdata = st_cnt[31:0];
        else if (off == OFF_ST_HI) begin
          bus_rdata[STAMP_HI_W-1:0] = st_cnt[STAMP_W-1:32];
          bus_rdata[STAMP_EN_BIT]   = st_en;
        end
      end else begin
        case (off)
          OFF_LOAD:  bus_rdata = ch_load[win];
          OFF_VALUE: bus_rdata = ch_val[win];
          OFF_CTRL:  bus_rdata = ch_ctrl[win];
          default:   bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
`timescale 1ns/1ps
module tmr_bank_chk #(
  parameter int STAMP_W = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         irq,
  input logic [31:0]        ch0_val,
  input logic               ch0_en,
  input logic [2:0]         ch_wr_ctrl,
  input logic [2:0]         ch_wr_clear,
  input logic               st_en,
  input logic [STAMP_W-1:0] st_cnt,
  input logic               fast_tick,
  input logic [5:0]         bus_addr,
  input logic [31:0]        bus_rdata
);
  a_r2_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch0_en && !ch_wr_ctrl[0]) |=> $stable(ch0_val));

  a_r6_irq_rises_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> ($past(ch0_val) == 32'd0));

  a_r6_irq_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq[0]) |-> $past(ch_wr_clear[0]));

  a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 6'h04) |-> (bus_rdata[31:16] == 16'd0));

  a_r9_stamp_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en |=> (st_cnt == '0));

  a_r9_stamp_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !fast_tick) |=> $stable(st_cnt));
endmodule

bind tmr_bank tmr_bank_chk #(.STAMP_W(STAMP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq         (irq),
  .ch0_val     (ch_val[0]),
  .ch0_en      (ch_en[0]),
  .ch_wr_ctrl  (wr_ctrl),
  .ch_wr_clear (wr_clear),
  .st_en       (st_en),
  .st_cnt      (st_cnt),
  .fast_tick   (fast_tick),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata)
);

// File: tb/test_tmr_bank.sv
`timescale 1ns/1ps
module test_tmr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        fast_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  always #10 clk = ~clk;

  tmr_bank i_tmr_bank (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    mon_go = 1'b0;
  bit    done = 1'b0;

  // Monitor: pops one expected item per observation slot
  initial begin
    forever begin
      @(posedge clk);
      if (mon_go) begin
        #5;
        if (sb.size() != 0) begin
          item_t it;
          logic [31:0] act;
          it  = sb.pop_front();
          act = it.is_irq ? {29'd0, irq} : bus_rdata;
          n_cmp++;
          if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
          end
        end
      end
    end
  end

  task automatic idle_drive();
    bus_wr = 1'b0; slow_tick = 1'b0; fast_tick = 1'b0;
  endtask

  task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    idle_drive();
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
  endtask

  task automatic expect_irq(input logic [2:0] e, input string tag);
    item_t it;
    @(negedge clk);
    idle_drive();
    it.is_irq = 1'b1; it.exp = {29'd0, e}; it.tag = tag;
    sb.push_back(it);
    mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    idle_drive();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    idle_drive();
  endtask

  task automatic slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle_drive(); slow_tick = 1'b1;
    end
    @(negedge clk); idle_drive();
  endtask

  task automatic fast(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle_drive(); fast_tick = 1'b1;
    end
    @(negedge clk); idle_drive();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(6'h08, 32'h0, "R1 ch0 ctrl after reset");
    expect_rd(6'h04, 32'h0, "R1 ch0 value after reset");
    expect_rd(6'h20, 32'h0, "R1 ch2 load after reset");
    expect_rd(6'h34, 32'h0, "R1 stamp high after reset");
    expect_irq(3'b000, "R1 irq after reset");

    // R7 disabled load write, R8 ctrl readback, R3 enable copies load
    wr(6'h08, 32'h48);
    wr(6'h00, 32'd4);
    expect_rd(6'h04, 32'h0, "R7 disabled load leaves value");
    expect_rd(6'h00, 32'd4, "R11 load readback");
    wr(6'h08, 32'hC8);
    expect_rd(6'h04, 32'd4, "R3 enable copies load");

    // R4 period of N ticks with load N-1, R6 irq set
    slow(4);
    expect_rd(6'h04, 32'd0, "R2 counted down to zero");
    expect_irq(3'b000, "R6 no irq before wrap");
    slow(1);
    expect_rd(6'h04, 32'd4, "R4 periodic reload");
    expect_irq(3'b001, "R6 irq on underflow");
    slow(4);
    expect_irq(3'b001, "R6 irq held until clear");
    wr(6'h0C, 32'h0);
    expect_irq(3'b000, "R6 clear write drops irq");

    // R6 underflow on same edge as clear keeps irq
    @(negedge clk);
    idle_drive();
    bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h0; slow_tick = 1'b1;
    @(negedge clk);
    idle_drive();
    expect_irq(3'b001, "R6 underflow beats clear");
    expect_rd(6'h04, 32'd4, "R4 reload after same-edge wrap");

    // R7 enabled load write replaces value; R10 value write ignored
    wr(6'h00, 32'd9);
    expect_rd(6'h04, 32'd9, "R7 enabled load replaces value");
    wr(6'h04, 32'h1234);
    expect_rd(6'h04, 32'd9, "R10 value write ignored");

    // R2 disabled channel holds
    wr(6'h08, 32'h48);
    slow(3);
    expect_rd(6'h04, 32'd9, "R2 disabled channel holds");

    // R2 tick select, R5 narrow free-running wrap, R8 masks
    wr(6'h18, 32'h80);
    expect_rd(6'h14, 32'd0, "R3 ch1 enable copies zero load");
    slow(2);
    expect_rd(6'h14, 32'd0, "R2 unselected slow tick ignored");
    fast(1);
    expect_rd(6'h14, 32'h0000FFFF, "R5 R8 narrow reload all ones");
    expect_irq(3'b011, "R6 ch1 irq on underflow");
    wr(6'h18, 32'hFF);
    expect_rd(6'h18, 32'hC8, "R8 ctrl keeps only defined bits");

    // R5 wide free-running wrap
    wr(6'h28, 32'h88);
    slow(1);
    expect_rd(6'h24, 32'hFFFFFFFF, "R5 wide reload all ones");
    expect_irq(3'b111, "R6 ch2 irq on underflow");

    // R9 timestamp, R10 low write ignored
    expect_rd(6'h30, 32'h0, "R9 stamp low while off");
    wr(6'h34, 32'h100);
    fast(5);
    slow(2);
    expect_rd(6'h30, 32'd5, "R9 stamp counts fast ticks only");
    expect_rd(6'h34, 32'h100, "R9 stamp high enable and upper count");
    wr(6'h30, 32'h777);
    expect_rd(6'h30, 32'd5, "R10 stamp low write ignored");
    wr(6'h34, 32'h0);
    expect_rd(6'h30, 32'd0, "R9 stamp cleared when disabled");

    // R11 unmapped and misaligned addresses
    expect_rd(6'h3C, 32'h0, "R11 unmapped reads zero");
    expect_rd(6'h05, 32'h0, "R11 misaligned reads zero");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule